// File: doc/BRIEF.md
# Endpoint MSI Write Generator

This block sits in a PCI Express endpoint. It turns a level interrupt request from inside the chip into a message-signaled interrupt. When the request line goes from low to high, it emits one memory-write request toward the transaction-layer packetizer. The packetizer frames that request into a packet.

The block holds a small set of MSI capability registers, all written through a simple register port:
- a control register with the enable bit;
- a low address register and a high address register;
- a 16-bit message data register.

The host sets these up at system initialization.

Each write request carries:
- a dword-aligned 64-bit target address;
- a 32-bit payload, which is the message data zero-extended;
- the byte enables;
- a flag that tells the packetizer whether a 32-bit or a 64-bit address header is needed.

The outgoing write uses valid/ready. Once `wr_valid` is high, it stays high and the request fields stay frozen until a cycle in which `wr_ready` is also high. The packetizer may hold `wr_ready` low for any number of cycles. The block never drops a request that is already presented. While one request is stalled, a single further edge can be remembered.

Top module: `msi_gen`

## Requirements
- R1: A write request is started only by a low-to-high transition of `irq_in`. A line held high yields exactly one write.
- R2: While the enable bit (bit 0 of the control register, register index 0) is clear, transitions of `irq_in` produce no write and are not remembered.
- R3: The request address is {high address register (index 2), low address register (index 1)}. Bits 1:0 of the low address register always read back as zero and are zero in the address.
- R4: The payload is the 16-bit message data register (index 3) in bits 15:0, with bits 31:16 equal to zero.
- R5: `wr_is64` is 0 when the high address register is zero, and 1 otherwise.
- R6: `wr_be` is 4'b1111 whenever `wr_valid` is high. `wr_valid` and all request fields hold steady until `wr_ready` is seen high. Register writes made meanwhile do not alter the presented request.
- R7: A rising edge that arrives while a request is stalled becomes one pending request. That pending request is presented in the cycle after the stalled one is accepted. Any number of extra edges during the stall merge into that single pending request.
- R8: Clearing the enable bit discards a pending request. A request already presented is still completed.
- R9: After reset, `wr_valid` is 0 and all registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 1 | Level interrupt request |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index: 0 control, 1 addr low, 2 addr high, 3 data |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_data | output | 32 | Read data of register at `reg_addr` |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Packetizer accepts the request |
| wr_addr | output | 64 | Target address |
| wr_data | output | 32 | Payload |
| wr_be | output | 4 | Byte enables |
| wr_is64 | output | 1 | 64-bit address header needed |

## Verification
A table of address and data settings covers several patterns:
- a zero high word;
- non-zero high words;
- low addresses with their bottom bits set;
- data values with the top bit set.

Together these separate correct zero-extension, alignment masking and the address-width flag from sign-extension or pass-through errors.

Directed sequences cover:
- a held-high line, which separates edge triggering from level triggering;
- edges with the enable cleared, which show whether the enable gate works;
- repeated edges under back-pressure, which separate merging into one pending request from queueing several or losing all;
- a disable during that stall, which shows whether the pending request is discarded.

// File: rtl/msi_pkg.sv
package msi_pkg;
  localparam int ADDR_W = 64;
  localparam int DATA_W = 32;
  localparam int MSG_W  = 16;
  localparam int REG_W  = 32;
  localparam int BE_W   = DATA_W / 8;
  localparam int ALIGN_BITS = 2;

  typedef enum logic [1:0] {
    RIDX_CTRL = 2'd0,
    RIDX_ALO  = 2'd1,
    RIDX_AHI  = 2'd2,
    RIDX_DATA = 2'd3
  } reg_idx_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic [BE_W-1:0]   be;
    logic              is64;
  } msi_req_t;
endpackage

// File: rtl/msi_cap_regs.sv
module msi_cap_regs
  import msi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        idx,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic              enable,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic [MSG_W-1:0]  msg
);
  localparam int HI_W = ADDR_W - REG_W;

  logic              en_q;
  logic [REG_W-1:0]  alo_q;
  logic [HI_W-1:0]   ahi_q;
  logic [MSG_W-1:0]  msg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      alo_q <= '0;
      ahi_q <= '0;
      msg_q <= '0;
    end else if (wr_en) begin
      case (reg_idx_e'(idx))
        RIDX_CTRL: en_q  <= wdata[0];
        RIDX_ALO:  alo_q <= {wdata[REG_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
        RIDX_AHI:  ahi_q <= wdata[HI_W-1:0];
        RIDX_DATA: msg_q <= wdata[MSG_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_idx_e'(idx))
      RIDX_CTRL: rdata = {{(REG_W-1){1'b0}}, en_q};
      RIDX_ALO:  rdata = alo_q;
      RIDX_AHI:  rdata = ahi_q;
      RIDX_DATA: rdata = {{(REG_W-MSG_W){1'b0}}, msg_q};
      default:   rdata = '0;
    endcase
  end

  assign enable   = en_q;
  assign tgt_addr = {ahi_q, alo_q};
  assign msg      = msg_q;
endmodule

// File: rtl/msi_trigger.sv
module msi_trigger (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_in,
  input  logic enable,
  input  logic slot_free,
  output logic issue
);
  logic irq_d;
  logic pend_q;
  logic edge_seen;

  assign edge_seen = irq_in & ~irq_d;
  assign issue     = enable & slot_free & (edge_seen | pend_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_d  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      irq_d <= irq_in;
      if (!enable)
        pend_q <= 1'b0;
      else if (issue)
        pend_q <= 1'b0;
      else if (edge_seen && !slot_free)
        pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/msi_req_stage.sv
module msi_req_stage
  import msi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic [MSG_W-1:0]  msg,
  input  logic              ready,
  output logic              valid,
  output logic              slot_free,
  output msi_req_t          req
);
  localparam int HI_W = ADDR_W - REG_W;

  logic     valid_q;
  msi_req_t req_q;
  msi_req_t req_next;

  always_comb begin
    req_next.addr = tgt_addr;
    req_next.data = {{(DATA_W-MSG_W){1'b0}}, msg};
    req_next.be   = {BE_W{1'b1}};
    req_next.is64 = |tgt_addr[ADDR_W-1:ADDR_W-HI_W];
  end

  assign slot_free = ~valid_q | ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      req_q   <= '0;
    end else if (issue) begin
      valid_q <= 1'b1;
      req_q   <= req_next;
    end else if (ready) begin
      valid_q <= 1'b0;
    end
  end

  assign valid = valid_q;
  assign req   = req_q;
endmodule

// File: rtl/msi_gen.sv
module msi_gen
  import msi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_in,
  input  logic              reg_wr_en,
  input  logic [1:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wr_data,
  output logic [REG_W-1:0]  reg_rd_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [BE_W-1:0]   wr_be,
  output logic              wr_is64
);
  logic              en_q;
  logic [ADDR_W-1:0] tgt_addr;
  logic [MSG_W-1:0]  msg;
  logic              slot_free;
  logic              issue;
  msi_req_t          req;

  msi_cap_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .idx(reg_addr),
    .wdata(reg_wr_data), .rdata(reg_rd_data), .enable(en_q),
    .tgt_addr(tgt_addr), .msg(msg)
  );

  msi_trigger u_trig (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .enable(en_q),
    .slot_free(slot_free), .issue(issue)
  );

  msi_req_stage u_out (
    .clk(clk), .rst_n(rst_n), .issue(issue), .tgt_addr(tgt_addr),
    .msg(msg), .ready(wr_ready), .valid(wr_valid),
    .slot_free(slot_free), .req(req)
  );

  assign wr_addr = req.addr;
  assign wr_data = req.data;
  assign wr_be   = req.be;
  assign wr_is64 = req.is64;
endmodule

// File: rtl/msi_gen_chk.sv
module msi_gen_chk
  import msi_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [BE_W-1:0]   wr_be,
  input logic              wr_is64
);
  AST_NEW_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !$past(wr_valid)) |-> $past(en)); // R2
  AST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_addr[1:0] == 2'b00)); // R3
  AST_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_data[DATA_W-1:MSG_W] == '0)); // R4
  AST_WIDTH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_is64 == (wr_addr[ADDR_W-1:REG_W] != '0))); // R5
  AST_FULL_BE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_be == {BE_W{1'b1}})); // R6
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data))); // R6
endmodule

bind msi_gen msi_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en_q), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
  .wr_be(wr_be), .wr_is64(wr_is64)
);

// File: tb/test_msi_gen.sv
module test_msi_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq_in = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wr_data = '0;
  logic [31:0] reg_rd_data;
  logic        wr_valid;
  logic        wr_ready = 1'b0;
  logic [63:0] wr_addr;
  logic [31:0] wr_data;
  logic [3:0]  wr_be;
  logic        wr_is64;

  int n_chk = 0;
  int n_fail = 0;
  int n_fire = 0;

  always #10 clk = ~clk;

  msi_gen i_msi_gen (.*);

  always @(posedge clk) if (rst_n && wr_valid && wr_ready) n_fire++;

  // {addr_lo, addr_hi, data}
  localparam logic [79:0] VEC [6] = '{
    {32'hFEE0_0000, 32'h0000_0000, 16'h0041},
    {32'hFEE0_1003, 32'h0000_0000, 16'hFFFF},
    {32'h1234_5679, 32'h0000_0001, 16'h8000},
    {32'h0000_0002, 32'hDEAD_BEEF, 16'h0000},
    {32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h7F01},
    {32'h0000_0004, 32'h8000_0000, 16'hA5A5}
  };

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wreg(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk); irq_in = 1'b1;
    @(negedge clk); irq_in = 1'b0;
  endtask

  task automatic accept();
    @(negedge clk); wr_ready = 1'b1;
    @(negedge clk); wr_ready = 1'b0;
  endtask

  initial begin
    #4_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check("R9 valid", wr_valid, 0);
    for (int r = 0; r < 4; r++) begin
      reg_addr = 2'(r); #1;
      check("R9 reg", reg_rd_data, 0);
    end

    wreg(2'd0, 32'h1);
    for (int i = 0; i < 6; i++) begin
      logic [31:0] lo, hi;
      logic [15:0] d;
      logic [63:0] ea;
      {lo, hi, d} = VEC[i];
      ea = {hi, lo & 32'hFFFF_FFFC};
      wreg(2'd1, lo); wreg(2'd2, hi); wreg(2'd3, {16'hBEEF, d});
      reg_addr = 2'd1; #1;
      check("R3 readback low bits", reg_rd_data, lo & 32'hFFFF_FFFC);
      pulse();
      check("R1 valid after edge", wr_valid, 1);
      check("R3 addr", wr_addr, ea);
      check("R4 data", wr_data, {48'h0, d});
      check("R5 is64", wr_is64, hi != 0);
      check("R6 be", wr_be, 4'hF);
      accept();
      check("R6 drop after accept", wr_valid, 0);
    end

    // R6 hold under stall and register writes
    pulse();
    wreg(2'd3, 32'h1234);
    wreg(2'd2, 32'h0);
    repeat (3) @(negedge clk);
    check("R6 still valid", wr_valid, 1);
    check("R6 data frozen", wr_data, 32'hA5A5);
    check("R6 addr frozen", wr_addr, 64'h8000_0000_0000_0004);
    accept();
    check("R6 released", wr_valid, 0);

    // R1 level held gives one write
    n_fire = 0;
    @(negedge clk); irq_in = 1'b1; wr_ready = 1'b1;
    repeat (8) @(negedge clk);
    irq_in = 1'b0; wr_ready = 1'b0;
    check("R1 single write on level", n_fire, 1);

    // R2 disabled
    wreg(2'd0, 32'h0);
    pulse(); pulse();
    check("R2 no write when disabled", wr_valid, 0);
    wreg(2'd0, 32'h1);
    repeat (2) @(negedge clk);
    check("R2 edges not remembered", wr_valid, 0);

    // R7 merge pending
    n_fire = 0;
    pulse(); pulse(); pulse(); pulse();
    check("R7 stalled valid", wr_valid, 1);
    accept();
    check("R7 pending issued", wr_valid, 1);
    accept();
    check("R7 done", wr_valid, 0);
    repeat (3) @(negedge clk);
    check("R7 merged count", n_fire, 2);
    check("R7 no extra", wr_valid, 0);

    // R8 disable discards pending
    n_fire = 0;
    pulse(); pulse();
    wreg(2'd0, 32'h0);
    check("R8 presented kept", wr_valid, 1);
    accept();
    repeat (3) @(negedge clk);
    check("R8 pending discarded", wr_valid, 0);
    check("R8 count", n_fire, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule